// File: doc/BRIEF.md
# Byte-Lane ECC Memory

This block is a synchronous 16-bit memory split into two byte lanes. Each lane keeps its own 12-bit codeword per address: eight data bits and four Hamming check bits. Writing a lane encodes that byte and stores the codeword. Reading a lane decodes that codeword and repairs a single flipped bit before the byte is returned. Because each lane is protected on its own, a partial write never has to read the other byte back. It also means one error in each lane of the same word can be repaired at once.

Control pins are active-low: chip enable, write enable, output enable and one enable per byte lane. The upper lane enable covers bits 15:8 and the lower lane enable covers bits 7:0. Read data appears one clock after the request. It is given as a data bus plus one drive-enable bit per lane, which models a tri-state output. A test-only injection port flips one chosen stored bit. It lets a testbench show that correction works. Depth is set by the address-width parameter: the full-size configuration uses 18 address bits, and the default is small.

Top module: `bytelane_ecc_mem`

## Requirements
- R1: While reset is low at a clock edge, and in the cycle after, `rdata`, `lane_oe` and `corr_flag` are all zero.
- R2: A cycle with `ce_n` high gives `lane_oe` = 00 in the next cycle, and it changes no stored data, whatever the other pins are.
- R3: A cycle with `ce_n` low, `we_n` high and `oe_n` low is a read. In the next cycle `lane_oe[0]` is the inverse of `lb_n` and `lane_oe[1]` is the inverse of `ub_n`. `rdata[7:0]` and `rdata[15:8]` hold the corrected byte of each driven lane and are zero for a lane that is not driven. With `oe_n` high, or with both lane enables high, `lane_oe` is 00.
- R4: A cycle with `ce_n` low, `we_n` low and at least one lane enable low writes only the lanes whose enable is low. The level of `oe_n` has no effect, and `lane_oe` is 00 in the next cycle.
- R5: Each lane codeword has positions 1 to 12. The check bits sit at positions 1, 2, 4 and 8, and data bits 0 to 7 sit, in order, at positions 3, 5, 6, 7, 9, 10, 11 and 12. A single flipped bit at any of the 12 positions is corrected on read.
- R6: Correction runs separately in each lane, so one flipped bit in each lane of the same word is corrected in a single read.
- R7: `corr_flag[i]` is high in the cycle after a read of lane i whose stored codeword has a nonzero syndrome. It is low after a read of a clean codeword, and low in every cycle that does not follow a read of lane i.
- R8: When `inj_en` is high at a clock edge, the stored bit at position `inj_pos` (1 to 12) is flipped. That bit belongs to lane `inj_lane` (0 = lower, 1 = upper) at address `inj_addr`, and the flip stays until that lane is written again. An `inj_pos` of 0 or 13 to 15 has no effect.
- R9: If a write and an injection hit the same lane and address in the same cycle, the write wins and the stored codeword is clean. An injection into the other lane in that cycle still takes effect.
- R10: A read in the same cycle as an injection at the same address returns the contents as they were before the injection.
- R11: Writing one lane leaves the other lane's data and check bits exactly as they were, including any injected error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the output registers |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| ub_n | input | 1 | Upper lane (bits 15:8) enable, active low |
| lb_n | input | 1 | Lower lane (bits 7:0) enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Corrected read data, one cycle after the read |
| lane_oe | output | 2 | Per-lane drive enable of the tri-state model |
| corr_flag | output | 2 | Per-lane corrected-error pulse |
| inj_en | input | 1 | Injection strobe |
| inj_lane | input | 1 | Lane to inject into |
| inj_pos | input | 4 | Codeword position to flip, 1 to 12 |
| inj_addr | input | ADDR_W | Address to inject into |

## Verification
An injection can land in the same cycle as a write to the same address, or in the same cycle as a read of it. The bench drives both on purpose. It issues a lane write and an injection aimed at that lane's address together, then does the same with the injection aimed at the other lane. It also issues a read and an injection at one address together. The scoreboard expects the write to win in the first case, the other lane to keep its error in the second, and the read to return the old clean contents. The following read must then raise the flag.

// File: rtl/blm_pkg.sv
// Package blm_pkg: shared sizes and Hamming helper functions for the
// byte-lane ECC memory. Codeword positions run 1..CW_W; position p is
// stored at vector bit p-1. Powers of two hold check bits.
package blm_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 2;
    localparam int POS_W  = 4;
    localparam int CW_W   = BYTE_W + POS_W;

    // Build a codeword: place data at non-power-of-two positions, then
    // set each check bit so that its parity group XORs to zero.
    function automatic logic [CW_W-1:0] ecc_encode(input logic [BYTE_W-1:0] d);
        logic [CW_W-1:0] cw;
        int j;
        cw = '0;
        j = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[p-1] = d[j];
                j++;
            end
        end
        for (int k = 0; k < POS_W; k++) begin
            logic par;
            par = 1'b0;
            for (int p = 1; p <= CW_W; p++) begin
                if (((p >> k) & 1) == 1 && p != (1 << k))
                    par = par ^ cw[p-1];
            end
            cw[(1 << k) - 1] = par;
        end
        return cw;
    endfunction

    // XOR of the positions of all set bits; zero for a clean codeword.
    function automatic logic [POS_W-1:0] ecc_syndrome(input logic [CW_W-1:0] cw);
        logic [POS_W-1:0] s;
        s = '0;
        for (int p = 1; p <= CW_W; p++) begin
            if (cw[p-1])
                s = s ^ POS_W'(p);
        end
        return s;
    endfunction

    // Pull the data byte back out of the non-power-of-two positions.
    function automatic logic [BYTE_W-1:0] ecc_extract(input logic [CW_W-1:0] cw);
        logic [BYTE_W-1:0] d;
        int j;
        d = '0;
        j = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                d[j] = cw[p-1];
                j++;
            end
        end
        return d;
    endfunction
endpackage

// File: rtl/blm_mode_dec.sv
// Module blm_mode_dec: turns the active-low control pins into per-lane
// write and read strobes. Assumes pins are synchronous to the clock.
// Lane 0 is the lower byte, lane 1 the upper byte.
module blm_mode_dec
    import blm_pkg::*;
(
    input  logic             ce_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [LANES-1:0] be_n,
    output logic [LANES-1:0] lane_wr,
    output logic [LANES-1:0] lane_rd
);
    logic wr_mode;
    logic rd_mode;

    // Decode the cycle type; output enable plays no part in a write.
    always_comb begin
        wr_mode = !ce_n && !we_n && (be_n != {LANES{1'b1}});
        rd_mode = !ce_n && we_n && !oe_n;
        lane_wr = wr_mode ? ~be_n : '0;
        lane_rd = rd_mode ? ~be_n : '0;
    end
endmodule

// File: rtl/blm_lane_encoder.sv
// Module blm_lane_encoder: combinational Hamming encoder for one byte lane.
// Assumes nothing beyond a valid data byte at its input.
module blm_lane_encoder
    import blm_pkg::*;
(
    input  logic [BYTE_W-1:0] data_in,
    output logic [CW_W-1:0]   cw_out
);
    // Form the 12-bit codeword.
    always_comb cw_out = ecc_encode(data_in);
endmodule

// File: rtl/blm_lane_corrector.sv
// Module blm_lane_corrector: combinational single-error corrector for one
// lane. A nonzero syndrome in range names the position to flip. A syndrome
// above CW_W cannot come from one error and is reported but not applied.
module blm_lane_corrector
    import blm_pkg::*;
(
    input  logic [CW_W-1:0]   cw_in,
    output logic [BYTE_W-1:0] data_out,
    output logic              err_seen
);
    logic [POS_W-1:0] syn;
    logic [CW_W-1:0]  fixed;

    // Compute the syndrome, flip the named bit, extract the byte.
    always_comb begin
        syn   = ecc_syndrome(cw_in);
        fixed = cw_in;
        if (syn != '0 && syn <= POS_W'(CW_W))
            fixed[syn - POS_W'(1)] = ~cw_in[syn - POS_W'(1)];
        data_out = ecc_extract(fixed);
        err_seen = (syn != '0);
    end
endmodule

// File: rtl/blm_lane_store.sv
// Module blm_lane_store: codeword array for one lane with an asynchronous
// read port and a test flip port. The array has no reset, so an address
// reads undefined until written. A write to the same address as a flip in
// the same cycle takes priority over the flip.
module blm_lane_store
    import blm_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CW_W-1:0]   wr_cw,
    input  logic              flip_en,
    input  logic [ADDR_W-1:0] flip_addr,
    input  logic [CW_W-1:0]   flip_mask,
    output logic [CW_W-1:0]   rd_cw
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [CW_W-1:0] mem [DEPTH];

    // Update the array: write the fresh codeword, apply a flip elsewhere.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[addr] <= wr_cw;
        if (flip_en && !(wr_en && flip_addr == addr))
            mem[flip_addr] <= mem[flip_addr] ^ flip_mask;
    end

    // Present the stored codeword at the access address.
    always_comb rd_cw = mem[addr];
endmodule

// File: rtl/bytelane_ecc_mem.sv
// Module bytelane_ecc_mem: 16-bit memory made of two independently
// ECC-protected byte lanes. Reads are registered: data, per-lane drive
// enables and correction flags appear one cycle after the request. Reset
// is synchronous, active low, and clears only the output registers.
module bytelane_ecc_mem
    import blm_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce_n,
    input  logic                    we_n,
    input  logic                    oe_n,
    input  logic                    ub_n,
    input  logic                    lb_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*BYTE_W-1:0] wdata,
    output logic [LANES*BYTE_W-1:0] rdata,
    output logic [LANES-1:0]        lane_oe,
    output logic [LANES-1:0]        corr_flag,
    input  logic                    inj_en,
    input  logic                    inj_lane,
    input  logic [POS_W-1:0]        inj_pos,
    input  logic [ADDR_W-1:0]       inj_addr
);
    logic [LANES-1:0]             lane_wr;
    logic [LANES-1:0]             lane_rd;
    logic [LANES-1:0][BYTE_W-1:0] fix_data;
    logic [LANES-1:0]             fix_err;
    logic                         pos_ok;
    logic [CW_W-1:0]              inj_mask;

    blm_mode_dec u_dec (
        .ce_n    (ce_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .be_n    ({ub_n, lb_n}),
        .lane_wr (lane_wr),
        .lane_rd (lane_rd)
    );

    // Validate the injection position and form its one-hot mask.
    always_comb begin
        pos_ok   = inj_en && inj_pos >= POS_W'(1) && inj_pos <= POS_W'(CW_W);
        inj_mask = CW_W'(1) << (inj_pos - POS_W'(1));
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [CW_W-1:0] enc_cw;
        logic [CW_W-1:0] rd_cw;
        logic            flip_en;

        // Route the injection to this lane only.
        always_comb flip_en = pos_ok && (inj_lane == 1'(g));

        blm_lane_encoder u_enc (
            .data_in (wdata[g*BYTE_W +: BYTE_W]),
            .cw_out  (enc_cw)
        );

        blm_lane_store #(.ADDR_W(ADDR_W)) u_store (
            .clk       (clk),
            .wr_en     (lane_wr[g]),
            .addr      (addr),
            .wr_cw     (enc_cw),
            .flip_en   (flip_en),
            .flip_addr (inj_addr),
            .flip_mask (inj_mask),
            .rd_cw     (rd_cw)
        );

        blm_lane_corrector u_fix (
            .cw_in    (rd_cw),
            .data_out (fix_data[g]),
            .err_seen (fix_err[g])
        );
    end

    // Register the read result of every lane; undriven lanes read zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata     <= '0;
            lane_oe   <= '0;
            corr_flag <= '0;
        end else begin
            for (int i = 0; i < LANES; i++) begin
                rdata[i*BYTE_W +: BYTE_W] <= lane_rd[i] ? fix_data[i] : '0;
                lane_oe[i]                <= lane_rd[i];
                corr_flag[i]              <= lane_rd[i] && fix_err[i];
            end
        end
    end
endmodule

// File: rtl/blm_checker.sv
// Module blm_checker: timing properties of the byte-lane ECC memory,
// observed at its ports only. Attached to every instance by bind.
module blm_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        ce_n,
    input logic        we_n,
    input logic        oe_n,
    input logic        ub_n,
    input logic        lb_n,
    input logic [15:0] rdata,
    input logic [1:0]  lane_oe,
    input logic [1:0]  corr_flag
);
    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (lane_oe == 2'b00)); // R2

    AST_READ_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && we_n && !oe_n) |=> (lane_oe == ~$past({ub_n, lb_n}))); // R3

    AST_OE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (we_n && oe_n) |=> (lane_oe == 2'b00)); // R3

    AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_oe[0] || rdata[7:0] == 8'h00) && (lane_oe[1] || rdata[15:8] == 8'h00)); // R3

    AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |=> (lane_oe == 2'b00)); // R4

    AST_FLAG_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_flag & ~lane_oe) == 2'b00); // R7
endmodule

bind bytelane_ecc_mem blm_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .ub_n      (ub_n),
    .lb_n      (lb_n),
    .rdata     (rdata),
    .lane_oe   (lane_oe),
    .corr_flag (corr_flag)
);

// File: tb/sim_bytelane_ecc_mem.sv
// Bench sim_bytelane_ecc_mem: scoreboard bench. The driver task applies one
// cycle of pins, predicts the registered outputs from a byte-level model and
// queues them; the monitor pops and compares mid-cycle after the next edge.
`timescale 1ns/1ps
module sim_bytelane_ecc_mem;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic [1:0]    lane_oe;
    logic [1:0]    corr_flag;
    logic          inj_en = 1'b0, inj_lane = 1'b0;
    logic [3:0]    inj_pos = '0;
    logic [AW-1:0] inj_addr = '0;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic [7:0] mdl [2][DEPTH];
    bit         merr [2][DEPTH];

    logic [15:0] exp_d_q [$];
    logic [1:0]  exp_oe_q [$];
    logic [1:0]  exp_fl_q [$];
    int          due_q [$];
    string       tag_q [$];

    bytelane_ecc_mem #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .wdata(wdata), .rdata(rdata),
        .lane_oe(lane_oe), .corr_flag(corr_flag), .inj_en(inj_en),
        .inj_lane(inj_lane), .inj_pos(inj_pos), .inj_addr(inj_addr)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every expectation due in this cycle.
    always @(posedge clk) begin
        #4;
        while (due_q.size() > 0 && due_q[0] == cyc) begin
            logic [15:0] ed;
            logic [1:0]  eo, ef;
            string       t;
            ed = exp_d_q.pop_front();
            eo = exp_oe_q.pop_front();
            ef = exp_fl_q.pop_front();
            t  = tag_q.pop_front();
            void'(due_q.pop_front());
            total++;
            if (rdata !== ed || lane_oe !== eo || corr_flag !== ef) begin
                bad++;
                $display("FAIL %s: got data=%h oe=%b flag=%b, expected data=%h oe=%b flag=%b",
                         t, rdata, lane_oe, corr_flag, ed, eo, ef);
            end
        end
    end

    // Driver: one cycle of pins, prediction, then model update.
    task automatic op(input logic c, input logic w, input logic o, input logic u,
                      input logic l, input logic [AW-1:0] a, input logic [15:0] wd,
                      input logic ie, input logic il, input logic [3:0] ip,
                      input logic [AW-1:0] ia, input string tag);
        logic [1:0]  be;
        logic [1:0]  eo, ef, lwr;
        logic [15:0] ed;
        bit          rd, wr;
        @(posedge clk);
        #1;
        ce_n = c; we_n = w; oe_n = o; ub_n = u; lb_n = l; addr = a; wdata = wd;
        inj_en = ie; inj_lane = il; inj_pos = ip; inj_addr = ia;
        be = {u, l};
        rd = !c && w && !o;
        wr = !c && !w && (be != 2'b11);
        eo = '0; ef = '0; ed = '0; lwr = '0;
        for (int k = 0; k < 2; k++) begin
            if (rd && !be[k]) begin
                eo[k] = 1'b1;
                ef[k] = merr[k][a];
                ed[k*8 +: 8] = mdl[k][a];
            end
            lwr[k] = wr && !be[k];
        end
        exp_d_q.push_back(ed);
        exp_oe_q.push_back(eo);
        exp_fl_q.push_back(ef);
        due_q.push_back(cyc + 1);
        tag_q.push_back(tag);
        for (int k = 0; k < 2; k++) begin
            if (lwr[k]) begin
                mdl[k][a]  = wd[k*8 +: 8];
                merr[k][a] = 1'b0;
            end
        end
        if (ie && ip >= 4'd1 && ip <= 4'd12 && !(lwr[il] && ia == a))
            merr[il][ia] = 1'b1;
    endtask

    task automatic wr_op(input logic [AW-1:0] a, input logic [15:0] d, input logic u,
                         input logic l, input logic o, input string tag);
        op(1'b0, 1'b0, o, u, l, a, d, 1'b0, 1'b0, 4'd0, '0, tag);
    endtask

    task automatic rd_op(input logic [AW-1:0] a, input logic u, input logic l,
                         input string tag);
        op(1'b0, 1'b1, 1'b0, u, l, a, 16'h0000, 1'b0, 1'b0, 4'd0, '0, tag);
    endtask

    task automatic inj_op(input logic il, input logic [3:0] ip, input logic [AW-1:0] ia,
                          input string tag);
        op(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0, 16'h0000, 1'b1, il, ip, ia, tag);
    endtask

    task automatic idle_op(input string tag);
        op(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0, 16'h0000, 1'b0, 1'b0, 4'd0, '0, tag);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: got running, expected finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 2; k++)
            for (int a = 0; a < DEPTH; a++) begin
                mdl[k][a] = 8'h00; merr[k][a] = 1'b0;
            end
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: outputs cleared by reset
        total++;
        if (rdata !== 16'h0 || lane_oe !== 2'b00 || corr_flag !== 2'b00) begin
            bad++;
            $display("FAIL R1: got data=%h oe=%b flag=%b, expected 0000 00 00",
                     rdata, lane_oe, corr_flag);
        end

        // R4: full write with output enable low, then R3 read variants
        wr_op(6'd5, 16'hA53C, 1'b0, 1'b0, 1'b0, "R4 write oe_n low");
        rd_op(6'd5, 1'b0, 1'b0, "R3 read both lanes");
        rd_op(6'd5, 1'b1, 1'b0, "R3 read lower only");
        rd_op(6'd5, 1'b0, 1'b1, "R3 read upper only");
        rd_op(6'd5, 1'b1, 1'b1, "R3 read no lane");
        op(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 6'd5, 16'h0, 1'b0, 1'b0, 4'd0, '0, "R3 oe_n high");

        // R2: deselected write attempt changes nothing
        op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd5, 16'h0000, 1'b0, 1'b0, 4'd0, '0, "R2 deselect");
        rd_op(6'd5, 1'b0, 1'b0, "R2 data kept");

        // R4: upper-only write
        wr_op(6'd5, 16'h77EE, 1'b0, 1'b1, 1'b1, "R4 upper write");
        rd_op(6'd5, 1'b0, 1'b0, "R4 lower kept");

        // R5 / R7: every position in both lanes
        for (int p = 1; p <= 12; p++) begin
            for (int k = 0; k < 2; k++) begin
                wr_op(6'd10, {8'(8'h5A ^ p), 8'(8'hC3 + p)}, 1'b0, 1'b0, 1'b1, "R5 setup");
                inj_op(1'(k), 4'(p), 6'd10, "R8 inject");
                rd_op(6'd10, 1'b0, 1'b0, "R5 corrected position");
            end
        end

        // R6: one error in each lane at once
        wr_op(6'd11, 16'h3CC3, 1'b0, 1'b0, 1'b1, "R6 setup");
        inj_op(1'b0, 4'd3, 6'd11, "R6 inject lower");
        inj_op(1'b1, 4'd9, 6'd11, "R6 inject upper");
        rd_op(6'd11, 1'b0, 1'b0, "R6 both corrected");
        // R7: flag repeats on re-read, drops on idle and after rewrite
        idle_op("R7 flag one cycle");
        rd_op(6'd11, 1'b1, 1'b0, "R7 lower flag only");
        wr_op(6'd11, 16'h0F0F, 1'b0, 1'b0, 1'b1, "R7 rewrite");
        rd_op(6'd11, 1'b0, 1'b0, "R7 clean read");

        // R8: out-of-range positions ignored
        wr_op(6'd12, 16'h9966, 1'b0, 1'b0, 1'b1, "R8 setup");
        inj_op(1'b0, 4'd0, 6'd12, "R8 pos 0");
        inj_op(1'b1, 4'd13, 6'd12, "R8 pos 13");
        inj_op(1'b1, 4'd15, 6'd12, "R8 pos 15");
        rd_op(6'd12, 1'b0, 1'b0, "R8 no effect");

        // R9: write beats same-lane injection, other lane keeps its flip
        op(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 6'd20, 16'h00B7, 1'b1, 1'b0, 4'd5, 6'd20, "R9 same lane");
        rd_op(6'd20, 1'b1, 1'b0, "R9 write wins");
        wr_op(6'd20, 16'h4400, 1'b0, 1'b1, 1'b1, "R9 upper setup");
        op(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 6'd20, 16'h0021, 1'b1, 1'b1, 4'd2, 6'd20, "R9 other lane");
        rd_op(6'd20, 1'b0, 1'b0, "R9 other lane flipped");

        // R10: read sees contents before a same-cycle injection
        wr_op(6'd21, 16'hDEAD, 1'b0, 1'b0, 1'b1, "R10 setup");
        op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'd21, 16'h0, 1'b1, 1'b0, 4'd12, 6'd21, "R10 read with inject");
        rd_op(6'd21, 1'b0, 1'b0, "R10 later read flagged");

        // R11: lower write keeps upper lane error and data
        wr_op(6'd22, 16'hBEEF, 1'b0, 1'b0, 1'b1, "R11 setup");
        inj_op(1'b1, 4'd8, 6'd22, "R11 inject upper check bit");
        wr_op(6'd22, 16'h0011, 1'b1, 1'b0, 1'b1, "R11 lower write");
        rd_op(6'd22, 1'b0, 1'b0, "R11 upper untouched");

        idle_op("R2 final idle");
        repeat (3) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule